// File: doc/BRIEF.md
# AXI-Stream Synchronous FIFO Queue

This block is a single-clock first-in first-out buffer for AXI-Stream beats. Beats enter through a slave port and leave through a master port in the same order. Each beat carries a data payload that is a whole number of bytes wide. It also carries a set of sideband fields: a per-byte strobe mask, a per-byte keep mask, an end-of-packet flag, a stream identifier, a routing destination and user bits. All fields of a beat travel through the queue together and come out unchanged.

The queue holds up to `DEPTH` beats, and `DEPTH` is a power of two. A registered occupancy output reports how many beats are held. The count never reports fewer beats than are stored. An accepted write shows up in the count one clock edge after it is taken.

The read side is driven from an output register. Its payload and sideband outputs therefore never depend combinationally on the memory read address. An active-low synchronous reset empties the queue.

Top module: `axis_sync_fifo`

## Requirements
- R1: A beat moves on either port only in a cycle where that port's tvalid and tready are both high. Beats leave in exactly the order they were accepted.
- R2: While `DEPTH` beats are stored and `m_tready` is low, `s_tready` is low.
- R3: When the queue is full and `m_tready` is high, `s_tready` is high. A simultaneous write and read in that cycle leaves the count at `DEPTH`.
- R4: `count` is $clog2(DEPTH)+1 bits wide. One clock edge after any handshake, it equals the number of stored beats, and it never reports fewer beats than are held.
- R5: Outside reset, `m_tvalid` is high exactly when `count` is nonzero. A beat written into an empty queue is presented on the master port after the next clock edge.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and every master-side output holds its value over the next edge.
- R7: Each beat's fields come out unchanged: `tdata`, `tstrb`, `tkeep`, `tlast`, `tid`, `tdest` and `tuser`. Bit i of `tstrb` and bit i of `tkeep` qualify byte i of `tdata`, where byte 0 is bits 7:0.
- R8: While `rst_n` is low, `s_tready` and `m_tvalid` are low. After a clock edge with `rst_n` low, `count` is zero and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Write-side beat valid |
| s_tready | output | 1 | Write side can take a beat |
| s_tdata | input | DATA_W | Write payload |
| s_tstrb | input | DATA_W/8 | Write byte strobe mask |
| s_tkeep | input | DATA_W/8 | Write byte keep mask |
| s_tlast | input | 1 | Write end-of-packet flag |
| s_tid | input | ID_W | Write stream identifier |
| s_tdest | input | DEST_W | Write routing destination |
| s_tuser | input | USER_W | Write user bits |
| m_tvalid | output | 1 | Read-side beat valid |
| m_tready | input | 1 | Consumer accepts a beat |
| m_tdata | output | DATA_W | Read payload |
| m_tstrb | output | DATA_W/8 | Read byte strobe mask |
| m_tkeep | output | DATA_W/8 | Read byte keep mask |
| m_tlast | output | 1 | Read end-of-packet flag |
| m_tid | output | ID_W | Read stream identifier |
| m_tdest | output | DEST_W | Read routing destination |
| m_tuser | output | USER_W | Read user bits |
| count | output | $clog2(DEPTH)+1 | Number of beats stored |

## Verification
The assertions check several properties on every cycle:
- the count stays within bounds and moves by exactly the net handshakes;
- `m_tvalid` agrees with a nonzero count;
- write-side ready is withheld when full unless a read frees the slot;
- a stalled master beat holds still;
- both handshake outputs are low during reset.

Only the bench scenarios can show two further behaviours. The first is that beats emerge in order with every sideband field intact, which the bench checks against its own reference queue. The second is that the reset empties the queue in the middle of traffic.

// File: rtl/axis_sync_fifo.sv
module axis_sync_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEST_W = 4,
  parameter int USER_W = 4,
  localparam int NB    = DATA_W / 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [NB-1:0]     s_tstrb,
  input  logic [NB-1:0]     s_tkeep,
  input  logic              s_tlast,
  input  logic [ID_W-1:0]   s_tid,
  input  logic [DEST_W-1:0] s_tdest,
  input  logic [USER_W-1:0] s_tuser,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [NB-1:0]     m_tstrb,
  output logic [NB-1:0]     m_tkeep,
  output logic              m_tlast,
  output logic [ID_W-1:0]   m_tid,
  output logic [DEST_W-1:0] m_tdest,
  output logic [USER_W-1:0] m_tuser,
  output logic [CW-1:0]     count
);
  localparam int BW = DATA_W + 2 * NB + 1 + ID_W + DEST_W + USER_W;

  logic [BW-1:0] mem [DEPTH];
  logic [BW-1:0] in_beat, out_q;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] mcnt, cnt;
  logic          ov_q;
  logic          wr, rd, load, mem_empty, bypass, mem_wr, mem_rd;

  assign in_beat   = {s_tuser, s_tdest, s_tid, s_tlast, s_tkeep, s_tstrb, s_tdata};
  assign s_tready  = rst_n & ((cnt != CW'(DEPTH)) | m_tready);
  assign m_tvalid  = rst_n & ov_q;
  assign wr        = s_tvalid & s_tready;
  assign rd        = m_tvalid & m_tready;
  assign load      = ~ov_q | m_tready;
  assign mem_empty = (mcnt == '0);
  assign bypass    = load & mem_empty & wr;
  assign mem_wr    = wr & ~bypass;
  assign mem_rd    = load & ~mem_empty;
  assign count     = cnt;

  assign {m_tuser, m_tdest, m_tid, m_tlast, m_tkeep, m_tstrb, m_tdata} = out_q;

  always_ff @(posedge clk) begin
    if (mem_wr) mem[wptr] <= in_beat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      mcnt <= '0;
      cnt  <= '0;
      ov_q <= 1'b0;
    end else begin
      if (mem_wr) wptr <= wptr + 1'b1;
      if (mem_rd) rptr <= rptr + 1'b1;
      mcnt <= mcnt + CW'(mem_wr) - CW'(mem_rd);
      cnt  <= cnt + CW'(wr) - CW'(rd);
      if (load) ov_q <= mem_rd | bypass;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rd)      out_q <= mem[rptr];
    else if (bypass) out_q <= in_beat;
  end
endmodule

module axis_sync_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int BW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tvalid,
  input logic          s_tready,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic [CW-1:0] count,
  input logic [BW-1:0] m_beat
);
  logic wr, rd;
  assign wr = s_tvalid & s_tready;
  assign rd = m_tvalid & m_tready;

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + CW'($past(wr)) - CW'($past(rd)));

  // R5
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid == (count != '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !m_tready) |-> !s_tready);

  // R3
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && m_tready) |-> s_tready);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_beat)));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!s_tready && !m_tvalid));
endmodule

bind axis_sync_fifo axis_sync_fifo_chk #(.DEPTH(DEPTH), .BW(BW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .count(count), .m_beat(out_q)
);

// File: tb/axis_sync_fifo_test.sv
module axis_sync_fifo_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int DEST_W = 3;
  localparam int USER_W = 5;
  localparam int NB     = DATA_W / 8;
  localparam int CW     = $clog2(DEPTH) + 1;
  localparam int BW     = DATA_W + 2 * NB + 1 + ID_W + DEST_W + USER_W;

  logic clk = 0, rst_n = 0;
  logic s_tvalid = 0, m_tready = 0;
  logic [DATA_W-1:0] s_tdata = '0;
  logic [NB-1:0] s_tstrb = '0, s_tkeep = '0;
  logic s_tlast = 0;
  logic [ID_W-1:0] s_tid = '0;
  logic [DEST_W-1:0] s_tdest = '0;
  logic [USER_W-1:0] s_tuser = '0;
  logic s_tready, m_tvalid, m_tlast;
  logic [DATA_W-1:0] m_tdata;
  logic [NB-1:0] m_tstrb, m_tkeep;
  logic [ID_W-1:0] m_tid;
  logic [DEST_W-1:0] m_tdest;
  logic [USER_W-1:0] m_tuser;
  logic [CW-1:0] count;

  always #(PERIOD/2) clk = ~clk;

  axis_sync_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ID_W(ID_W), .DEST_W(DEST_W),
                   .USER_W(USER_W)) uut (.*);

  int total = 0, fails = 0;
  logic [BW-1:0] q [DEPTH];
  int head = 0, size = 0;
  logic stalled = 0;
  logic [BW-1:0] last_out;

  function automatic logic [BW-1:0] in_pack();
    return {s_tuser, s_tdest, s_tid, s_tlast, s_tkeep, s_tstrb, s_tdata};
  endfunction
  function automatic logic [BW-1:0] out_pack();
    return {m_tuser, m_tdest, m_tid, m_tlast, m_tkeep, m_tstrb, m_tdata};
  endfunction
  function automatic logic exp_ready(int n, logic rdy);
    return (n < DEPTH) || rdy;
  endfunction

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic r);
    logic w, rd;
    @(negedge clk);
    s_tvalid = v; m_tready = r;
    s_tdata = $urandom; s_tstrb = NB'($urandom); s_tkeep = NB'($urandom);
    s_tlast = 1'($urandom); s_tid = ID_W'($urandom);
    s_tdest = DEST_W'($urandom); s_tuser = USER_W'($urandom);
    #1;
    check("R4 count", BW'(count), BW'(size));
    check("R5 m_tvalid", BW'(m_tvalid), BW'(size != 0));
    check("R2/R3 s_tready", BW'(s_tready), BW'(exp_ready(size, r)));
    if (m_tvalid && size != 0) check("R1/R7 beat order and fields", out_pack(), q[head]);
    if (stalled) check("R6 stall hold", out_pack(), last_out);
    w  = v && exp_ready(size, r);
    rd = (size != 0) && r;
    stalled  = (size != 0) && !r;
    last_out = out_pack();
    if (rd) begin head = (head + 1) % DEPTH; size--; end
    if (w) begin q[(head + size) % DEPTH] = in_pack(); size++; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; s_tvalid = 1; m_tready = 1;
    #1;
    check("R8 s_tready in reset", BW'(s_tready), '0);
    check("R8 m_tvalid in reset", BW'(m_tvalid), '0);
    @(negedge clk);
    check("R8 count after reset", BW'(count), '0);
    rst_n = 1; s_tvalid = 0; m_tready = 0;
    size = 0; head = 0; stalled = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R5: single beat latency into empty queue
    step(1, 0);
    step(0, 0);
    step(0, 1);
    step(0, 0);
    // R2: fill to full with reader stalled, then try to overwrite
    for (int i = 0; i < DEPTH + 4; i++) step(1, 0);
    // R3: full with simultaneous write and read
    for (int i = 0; i < 6; i++) step(1, 1);
    // drain
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1);
    // random traffic at several densities
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, ($urandom % 4) == 0);
    for (int i = 0; i < 3000; i++) step(($urandom % 2) == 0, ($urandom % 2) == 0);
    for (int i = 0; i < 3000; i++) step(($urandom % 4) == 0, ($urandom % 4) != 0);
    // R8: reset in the middle of traffic
    for (int i = 0; i < 10; i++) step(1, 0);
    do_reset();
    for (int i = 0; i < 3; i++) step(0, 1);
    for (int i = 0; i < 2000; i++) step(($urandom % 3) != 0, ($urandom % 3) != 0);
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule